// File: doc/BRIEF.md
# Serial ADC Conversion Frame Sequencer

This block is the host side of a three-wire link to a serial sampling converter. From the system clock it makes a free-running serial clock and a conversion-start strobe that is one serial-clock period wide. The start strobe rises together with a serial-clock rising edge. The converter then returns its result on a single data line, MSB first, beginning two serial clocks into the frame. The sequencer samples that line on each falling edge of the serial clock. It assembles a right-aligned parallel word and marks that word with a one-cycle valid strobe.

The frame length in serial clocks and the word width are build-time parameters. The minimum frame is 16 clocks. Longer frames add acquisition time before the next start. The word width is 12 or 14 bits. An enable input gates frame starts. The enable is looked at only at a frame boundary, so a frame that has started always runs to completion and delivers its word.

Top module: `sadc_frame_seq`

## Requirements
- R1: `conv_o` rises on the same system-clock edge as a rising edge of `sclk_o` and stays high for exactly `SCLK_DIV` system clocks, which is one serial-clock period.
- R2: While `en` stays high, two successive rising edges of `conv_o` are separated by exactly `FRAME_LEN` rising edges of `sclk_o`, counting the edge that goes with the first start. The separation is never smaller than that.
- R3: `sclk_o` is the system clock divided by `SCLK_DIV`. It is high for `SCLK_DIV/2` system clocks and low for `SCLK_DIV/2` system clocks.
- R4: `sdi` is sampled on the system-clock edge where `sclk_o` falls. The serial-clock period that begins with the start edge is period index 0. Data bit k (k=0 is the MSB) is taken in period index 2+k.
- R5: `sample_o` holds the RES_BITS bits that were taken, right-aligned, with the first bit taken in bit RES_BITS-1. It keeps its value until the next valid strobe.
- R6: `valid_o` is high for exactly one system clock. It rises right after the fall of `sclk_o` in period index 2+RES_BITS-1, which is index 15 for 14 bits.
- R7: `en` is sampled at the serial-clock rising edge that would begin a new frame. If `en` is low there, no start pulse is made and no new word follows. A frame already under way still completes and delivers its word.
- R8: While `rst` is high, `sclk_o`, `conv_o`, `valid_o` and `sample_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Allows new frames to start |
| sdi | input | 1 | Serial data from the converter |
| sclk_o | output | 1 | Serial clock to the converter |
| conv_o | output | 1 | Conversion-start strobe |
| sample_o | output | RES_BITS | Assembled sample word, right-aligned |
| valid_o | output | 1 | One-cycle strobe marking a new sample |

## Verification
The converter model in the bench changes the data line half a system clock after each serial rising edge. A design that sampled on the rising edge would therefore return every word shifted by one bit. The words used are all ones, all zeros, the two alternating patterns, a lone MSB, a lone LSB, a block pattern and arithmetic-generated words. Together they separate bit-order faults, off-by-one faults in the capture window and stuck bits. Turning the enable off in the middle of a frame shows whether the frame in flight still completes while later starts are held back. Turning it back on shows whether framing resumes with the full spacing between starts.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    // Serial-clock periods from the start edge to the MSB period
    localparam int LEAD_PERIODS = 2;

    typedef struct packed {
        logic rise;   // sclk rises on this system-clock edge
        logic fall;   // sclk falls on this system-clock edge
    } sclk_evt_t;

    typedef struct packed {
        logic take;   // shift the data line in on this edge
        logic last;   // this is the final bit of the word
    } cap_ctl_t;

    function automatic int last_bit_period(input int res_bits);
        return LEAD_PERIODS + res_bits - 1;
    endfunction

endpackage

// File: rtl/sadc_clkgen.sv
module sadc_clkgen
    import sadc_pkg::*;
#(
    parameter int SCLK_DIV = 4
) (
    input  logic      clk,
    input  logic      rst,
    output logic      sclk_o,
    output sclk_evt_t evt_o
);
    localparam int PW = (SCLK_DIV > 2) ? $clog2(SCLK_DIV) : 1;
    localparam int HALF = SCLK_DIV / 2;
    localparam logic [PW-1:0] PH_LAST = PW'(SCLK_DIV - 1);
    localparam logic [PW-1:0] PH_MID  = PW'(HALF - 1);

    logic [PW-1:0] ph_q;
    logic          sclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= '0;
            sclk_q <= 1'b0;
        end else begin
            ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + PW'(1);
            if (ph_q == PH_LAST)
                sclk_q <= 1'b1;
            else if (ph_q == PH_MID)
                sclk_q <= 1'b0;
        end
    end

    always_comb begin
        evt_o.rise = (ph_q == PH_LAST);
        evt_o.fall = (ph_q == PH_MID);
    end

    assign sclk_o = sclk_q;
endmodule

// File: rtl/sadc_framer.sv
module sadc_framer
    import sadc_pkg::*;
#(
    parameter int FRAME_LEN = 18,
    parameter int RES_BITS  = 14
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  sclk_evt_t evt_i,
    output logic      conv_o,
    output cap_ctl_t  cap_o
);
    localparam int CW = $clog2(FRAME_LEN);
    localparam logic [CW-1:0] CYC_LAST  = CW'(FRAME_LEN - 1);
    localparam logic [CW-1:0] BIT_FIRST = CW'(LEAD_PERIODS);
    localparam logic [CW-1:0] BIT_LAST  = CW'(last_bit_period(RES_BITS));

    logic [CW-1:0] cyc_q;
    logic          active_q;
    logic          conv_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q    <= '0;
            active_q <= 1'b0;
            conv_q   <= 1'b0;
        end else if (evt_i.rise) begin
            if (!active_q || cyc_q == CYC_LAST) begin
                cyc_q    <= '0;
                active_q <= en;
                conv_q   <= en;
            end else begin
                cyc_q  <= cyc_q + CW'(1);
                conv_q <= 1'b0;
            end
        end
    end

    always_comb begin
        cap_o.take = evt_i.fall && active_q &&
                     (cyc_q >= BIT_FIRST) && (cyc_q <= BIT_LAST);
        cap_o.last = cap_o.take && (cyc_q == BIT_LAST);
    end

    assign conv_o = conv_q;
endmodule

// File: rtl/sadc_shifter.sv
module sadc_shifter
    import sadc_pkg::*;
#(
    parameter int RES_BITS = 14
) (
    input  logic                clk,
    input  logic                rst,
    input  cap_ctl_t            cap_i,
    input  logic                sdi,
    output logic [RES_BITS-1:0] sample_o,
    output logic                valid_o
);
    logic [RES_BITS-1:0] sh_q;
    logic [RES_BITS-1:0] sample_q;
    logic                valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q     <= '0;
            sample_q <= '0;
            valid_q  <= 1'b0;
        end else begin
            valid_q <= cap_i.last;
            if (cap_i.take)
                sh_q <= {sh_q[RES_BITS-2:0], sdi};
            if (cap_i.last)
                sample_q <= {sh_q[RES_BITS-2:0], sdi};
        end
    end

    assign sample_o = sample_q;
    assign valid_o  = valid_q;
endmodule

// File: rtl/sadc_frame_seq.sv
module sadc_frame_seq
    import sadc_pkg::*;
#(
    parameter int SCLK_DIV  = 4,
    parameter int FRAME_LEN = 18,
    parameter int RES_BITS  = 14
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                sdi,
    output logic                sclk_o,
    output logic                conv_o,
    output logic [RES_BITS-1:0] sample_o,
    output logic                valid_o
);
    sclk_evt_t evt;
    cap_ctl_t  cap;

    sadc_clkgen #(.SCLK_DIV(SCLK_DIV)) u_clkgen (
        .clk    (clk),
        .rst    (rst),
        .sclk_o (sclk_o),
        .evt_o  (evt)
    );

    sadc_framer #(.FRAME_LEN(FRAME_LEN), .RES_BITS(RES_BITS)) u_framer (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .evt_i  (evt),
        .conv_o (conv_o),
        .cap_o  (cap)
    );

    sadc_shifter #(.RES_BITS(RES_BITS)) u_shifter (
        .clk      (clk),
        .rst      (rst),
        .cap_i    (cap),
        .sdi      (sdi),
        .sample_o (sample_o),
        .valid_o  (valid_o)
    );
endmodule

// File: rtl/sadc_frame_seq_chk.sv
module sadc_frame_seq_chk #(
    parameter int SCLK_DIV  = 4,
    parameter int FRAME_LEN = 18,
    parameter int RES_BITS  = 14
) (
    input logic                clk,
    input logic                rst,
    input logic                en,
    input logic                sclk_o,
    input logic                conv_o,
    input logic [RES_BITS-1:0] sample_o,
    input logic                valid_o
);
    localparam int HALF = SCLK_DIV / 2;

    logic        sclk_d, conv_d, seen_tog, seen_conv;
    logic [15:0] run_cnt, edge_cnt;
    logic        tog, s_rise, c_rise;

    assign tog    = sclk_o != sclk_d;
    assign s_rise = sclk_o && !sclk_d;
    assign c_rise = conv_o && !conv_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d    <= 1'b0;
            conv_d    <= 1'b0;
            seen_tog  <= 1'b0;
            seen_conv <= 1'b0;
            run_cnt   <= '0;
            edge_cnt  <= '0;
        end else begin
            sclk_d <= sclk_o;
            conv_d <= conv_o;
            if (tog) begin
                run_cnt  <= 16'd1;
                seen_tog <= 1'b1;
            end else if (run_cnt != 16'hFFFF) begin
                run_cnt <= run_cnt + 16'd1;
            end
            if (c_rise) begin
                edge_cnt  <= 16'd1;
                seen_conv <= 1'b1;
            end else if (s_rise && edge_cnt != 16'hFFFF) begin
                edge_cnt <= edge_cnt + 16'd1;
            end
        end
    end

    p_conv_with_sclk_r1: assert property (@(posedge clk) disable iff (rst)
        c_rise |-> s_rise);

    p_frame_gap_r2: assert property (@(posedge clk) disable iff (rst)
        (c_rise && seen_conv) |-> (edge_cnt >= 16'(FRAME_LEN)));

    p_sclk_duty_r3: assert property (@(posedge clk) disable iff (rst)
        (tog && seen_tog) |-> (run_cnt == 16'(HALF)));

    p_sample_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> $stable(sample_o));

    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    p_start_needs_en_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(conv_o) |-> $past(en));

    p_reset_quiet_r8: assert property (@(posedge clk)
        rst |=> (!conv_o && !valid_o && !sclk_o));
endmodule

bind sadc_frame_seq sadc_frame_seq_chk #(
    .SCLK_DIV(SCLK_DIV), .FRAME_LEN(FRAME_LEN), .RES_BITS(RES_BITS)
) u_chk (
    .clk(clk), .rst(rst), .en(en), .sclk_o(sclk_o), .conv_o(conv_o),
    .sample_o(sample_o), .valid_o(valid_o)
);

// File: tb/sadc_frame_seq_bench.sv
module sadc_frame_seq_bench;
    localparam int DIV   = 4;
    localparam int FRAME = 18;
    localparam int RES   = 14;
    localparam int HALF  = DIV / 2;
    localparam int LEAD  = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic sdi = 1'b0;
    logic sclk_o, conv_o, valid_o;
    logic [RES-1:0] sample_o;

    always #5 clk = ~clk;

    sadc_frame_seq #(.SCLK_DIV(DIV), .FRAME_LEN(FRAME), .RES_BITS(RES)) u_sadc_frame_seq (
        .clk(clk), .rst(rst), .en(en), .sdi(sdi), .sclk_o(sclk_o),
        .conv_o(conv_o), .sample_o(sample_o), .valid_o(valid_o)
    );

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;
    logic [RES-1:0] exp_q[$];

    task automatic check(input bit ok, input string req, input int act, input int expv);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, expv, expv);
        end
    endtask

    task automatic push_expected(input logic [RES-1:0] w);
        exp_q.push_back(w);
    endtask

    function automatic logic [RES-1:0] word_for(input int i);
        case (i)
            0: return '1;
            1: return '0;
            2: return RES'(14'h2AAA);
            3: return RES'(14'h1555);
            4: return RES'(1) << (RES - 1);
            5: return RES'(1);
            6: return RES'(14'h3C0F);
            default: return RES'((i * 32'h2F1B) ^ 32'h1234);
        endcase
    endfunction

    // converter model and timing observer
    logic prev_sclk = 1'b0, prev_conv = 1'b0;
    int e = 100, started = 0, rises_since = 0, conv_len = 0, run = 0, toggles = 0;
    bit gap = 1'b0;
    logic [RES-1:0] cur = '0;

    always @(negedge clk) begin
        if (rst) begin
            prev_sclk = 1'b0; prev_conv = 1'b0; sdi = 1'b0;
        end else begin
            automatic bit s_rise = sclk_o && !prev_sclk;
            automatic bit c_rise = conv_o && !prev_conv;
            if (c_rise)
                check(s_rise, "R1 start with sclk rise", int'(s_rise), 1);
            if (s_rise) begin
                if (c_rise) begin
                    if (started > 0) begin
                        if (gap)
                            check(rises_since >= FRAME, "R2 gap after enable", rises_since, FRAME);
                        else
                            check(rises_since == FRAME, "R2 frame spacing", rises_since, FRAME);
                    end
                    gap = 1'b0;
                    rises_since = 1;
                    e = 0;
                    cur = word_for(started);
                    push_expected(cur);
                    started++;
                end else begin
                    rises_since++;
                    if (e < 100) e++;
                end
            end
            if (conv_o) conv_len++;
            if (!conv_o && prev_conv) begin
                check(conv_len == DIV, "R1 start width", conv_len, DIV);
                conv_len = 0;
            end
            if (sclk_o != prev_sclk) begin
                if (toggles >= 1 && toggles < 40)
                    check(run == HALF, "R3 sclk phase length", run, HALF);
                run = 1;
                toggles++;
            end else begin
                run++;
            end
            sdi = (e >= LEAD && e < LEAD + RES) ? cur[RES - 1 - (e - LEAD)] : 1'b0;
            prev_sclk = sclk_o;
            prev_conv = conv_o;
        end
    end

    // monitor
    logic prev_valid = 1'b0;
    int valids = 0;
    logic [RES-1:0] last_word = '0;

    always @(negedge clk) begin
        if (!rst) begin
            if (valid_o) begin
                check(!prev_valid, "R6 valid one cycle", int'(prev_valid), 0);
                check(e == LEAD + RES - 1, "R4 R6 valid period index", e, LEAD + RES - 1);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 unexpected word", int'(sample_o), 0);
                end else begin
                    last_word = exp_q.pop_front();
                    check(sample_o == last_word, "R5 R4 sample word", int'(sample_o), int'(last_word));
                end
                valids++;
            end
            prev_valid = valid_o;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!sclk_o && !conv_o && !valid_o, "R8 reset controls",
              int'({sclk_o, conv_o, valid_o}), 0);
        check(sample_o == '0, "R8 reset sample", int'(sample_o), 0);
        @(negedge clk);
        rst = 1'b0;
        en  = 1'b1;
        while (started < 10) @(negedge clk);
        repeat (DIV * 3) @(negedge clk);
        en = 1'b0;
        begin
            automatic int s0 = started;
            repeat (2 * FRAME * DIV) @(negedge clk);
            check(started == s0, "R7 no start while disabled", started, s0);
            check(valids == s0, "R7 frame in flight completes", valids, s0);
            repeat (5 * FRAME * DIV) @(negedge clk);
            check(started == s0, "R7 still idle", started, s0);
            check(sample_o == last_word, "R5 sample holds while idle", int'(sample_o), int'(last_word));
        end
        gap = 1'b1;
        en = 1'b1;
        while (started < 16) @(negedge clk);
        en = 1'b0;
        repeat (2 * FRAME * DIV) @(negedge clk);
        check(valids == started, "R7 all words delivered", valids, started);
        check(exp_q.size() == 0, "R5 scoreboard empty", exp_q.size(), 0);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual %0d expected %0d frames", started, 16);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule